// File: doc/BRIEF.md
# Key-Locked GPIO Port Controller

This block is a memory-mapped port of up to 32 general-purpose pads, programmed over a simple synchronous register bus. Each pad has a two-bit drive mode, split across two mode registers, and an output data bit. The mode and the data bit together give four pad behaviours: input, push-pull output, drive-low-only (open-drain) and drive-high-only (open-source).

The mode registers are guarded by a lock register. Mode writes land only after a 16-bit key has armed that lock. Output data is changed through write-one-to-set and write-one-to-clear addresses, so software never has to read, modify and write it back. Pad inputs pass through a two-flop synchroniser and can be read back. Each pad's output value and output enable go to an external pad wrapper.

Top module: `keylock_gpio_port`

## Requirements
- R1: After reset every mode bit and every output data bit is 0, so every pad_oe bit is 0. The lock register reads 0x00000000, and both mode registers read 0.
- R2: A write to the lock register (offset 0x60) whose bits 15:0 equal 0xD42F sets the lock-active flag, which reads back as bit 31. A write with bits 15:0 equal 0x0000 clears the flag. Any other value leaves the flag unchanged.
- R3: A write to mode1 (0x08), mode0 (0x0C), mode1-clear (0x50), mode0-set (0x54) or mode0-clear (0x58) changes nothing while the lock is inactive.
- R4: A pad whose {mode1,mode0} bits are 00 is an input: its pad_oe is 0 whatever its data bit.
- R5: A pad in mode 01 drives its data bit: pad_oe is 1 and pad_out equals the data bit.
- R6: A pad in mode 10 has pad_oe=1 and pad_out=0 when its data bit is 0. It has pad_oe=0 when its data bit is 1.
- R7: A pad in mode 11 has pad_oe=0 when its data bit is 0. It has pad_oe=1 and pad_out=1 when its data bit is 1.
- R8: Bit i of every register belongs to pad i. Data-set (0x14) and mode0-set set each bit that is written as 1. Data-clear (0x18), mode1-clear and mode0-clear clear each bit written as 1. A bit written as 0 keeps its value. A write to mode1 or mode0 loads the whole register.
- R9: The data-in register (0x04) returns the pad inputs through a two-flop synchroniser. A pad change applied in cycle n is returned by reads with rd_en in cycle n+2 or later. Reads with rd_en in cycle n or n+1 still return the previous value.
- R10: Register bits at or above NUM_PADS read as 0 and ignore writes.
- R11: bus_rd_data is registered. It is loaded in the cycle after rd_en and holds its value otherwise. Reads of the set, clear and unmapped addresses return 0.
- R12: pad_out and pad_oe follow a register write starting in the cycle right after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_data | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rd_data | output | 32 | Read data, valid the cycle after bus_rd_en |
| pad_in | input | NUM_PADS | Asynchronous pad input levels |
| pad_out | output | NUM_PADS | Value driven on each pad when enabled |
| pad_oe | output | NUM_PADS | Per-pad output enable |

## Verification
The bench goes after a few specific corner cases.

- Mode writes issued while the lock is inactive must change nothing. A design that fails to gate them would let a stray write turn an input into a driver.
- Lock writes with a value other than the key or zero must leave the flag unchanged. A flag that toggles on any write would unlock or relock at random.
- Modes 10 and 11 are checked with both data values. A swapped decode would drive an open-drain pad high and fight the external bus.
- Bits above NUM_PADS are written with ones and must read back as 0.
- Data-in is read in the two cycles after a pad change and must show the old value there. A missing synchroniser stage shows the new value one read early.

// File: rtl/klg_pkg.sv
package klg_pkg;
  localparam int unsigned DATA_W = 32;
  localparam logic [15:0] UNLOCK_KEY = 16'hD42F;
  localparam logic [15:0] RELOCK_KEY = 16'h0000;
  localparam logic [7:0] OFF_DIN     = 8'h04;
  localparam logic [7:0] OFF_MODE1   = 8'h08;
  localparam logic [7:0] OFF_MODE0   = 8'h0C;
  localparam logic [7:0] OFF_DSET    = 8'h14;
  localparam logic [7:0] OFF_DCLR    = 8'h18;
  localparam logic [7:0] OFF_M1CLR   = 8'h50;
  localparam logic [7:0] OFF_M0SET   = 8'h54;
  localparam logic [7:0] OFF_M0CLR   = 8'h58;
  localparam logic [7:0] OFF_LOCK    = 8'h60;

  function automatic logic [DATA_W-1:0] pad_mask(input int unsigned n);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < DATA_W; i++) if (i < n) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/klg_key_lock.sv
module klg_key_lock
  import klg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_hit,
  input  logic [15:0] key,
  output logic        lock_active
);
  logic act_q, act_n;

  always_comb begin
    act_n = act_q;
    if (wr_hit) begin
      if (key == UNLOCK_KEY)      act_n = 1'b1;
      else if (key == RELOCK_KEY) act_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      act_q <= 1'b0;
    else if (wr_hit) act_q <= act_n;
  end

  assign lock_active = act_q;

  assert_key_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && key == UNLOCK_KEY) |=> lock_active);
  assert_key_disarms_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && key == RELOCK_KEY) |=> !lock_active);
  assert_other_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && key != UNLOCK_KEY && key != RELOCK_KEY) |=> $stable(lock_active));
endmodule

// File: rtl/klg_port_regs.sv
module klg_port_regs
  import klg_pkg::*;
#(
  parameter int unsigned NUM_PADS = 20,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              lock_active,
  output logic [DATA_W-1:0] mode0,
  output logic [DATA_W-1:0] mode1,
  output logic [DATA_W-1:0] dout
);
  localparam logic [DATA_W-1:0] MASK = pad_mask(NUM_PADS);

  logic [DATA_W-1:0] m0_q, m1_q, d_q, m0_n, m1_n, d_n;
  logic [DATA_W-1:0] wbits;

  assign wbits = wdata & MASK;

  always_comb begin
    m0_n = m0_q;
    m1_n = m1_q;
    d_n  = d_q;
    if (wr_en) begin
      unique case (addr[7:0])
        OFF_DSET:  d_n = d_q | wbits;
        OFF_DCLR:  d_n = d_q & ~wbits;
        OFF_MODE1: if (lock_active) m1_n = wbits;
        OFF_MODE0: if (lock_active) m0_n = wbits;
        OFF_M1CLR: if (lock_active) m1_n = m1_q & ~wbits;
        OFF_M0SET: if (lock_active) m0_n = m0_q | wbits;
        OFF_M0CLR: if (lock_active) m0_n = m0_q & ~wbits;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m0_q <= '0;
      m1_q <= '0;
      d_q  <= '0;
    end else if (wr_en) begin
      m0_q <= m0_n;
      m1_q <= m1_n;
      d_q  <= d_n;
    end
  end

  assign mode0 = m0_q;
  assign mode1 = m1_q;
  assign dout  = d_q;

  assert_mode_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_active |=> ($stable(mode0) && $stable(mode1)));
  assert_unused_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode0 | mode1 | dout) & ~MASK) == '0);
  assert_dset_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[7:0] == OFF_DSET) |=> ((dout & $past(wbits)) == $past(wbits)));
  assert_dclr_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[7:0] == OFF_DCLR) |=> ((dout & $past(wbits)) == '0));
endmodule

// File: rtl/klg_pad_drive.sv
module klg_pad_drive #(
  parameter int unsigned NUM_PADS = 20
) (
  input  logic [NUM_PADS-1:0] mode0,
  input  logic [NUM_PADS-1:0] mode1,
  input  logic [NUM_PADS-1:0] dout,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe
);
  for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
    always_comb begin
      unique case ({mode1[i], mode0[i]})
        2'b01:   begin pad_oe[i] = 1'b1;     pad_out[i] = dout[i]; end
        2'b10:   begin pad_oe[i] = ~dout[i]; pad_out[i] = 1'b0;    end
        2'b11:   begin pad_oe[i] = dout[i];  pad_out[i] = 1'b1;    end
        default: begin pad_oe[i] = 1'b0;     pad_out[i] = 1'b0;    end
      endcase
    end
  end
endmodule

// File: rtl/klg_sync2.sv
module klg_sync2 #(
  parameter int unsigned WIDTH = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/keylock_gpio_port.sv
module keylock_gpio_port
  import klg_pkg::*;
#(
  parameter int unsigned NUM_PADS = 20,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr_en,
  input  logic [DATA_W-1:0]   bus_wr_data,
  input  logic                bus_rd_en,
  output logic [DATA_W-1:0]   bus_rd_data,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe
);
  logic rs1_q, rs2_q, rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_i_n = rs2_q;

  logic              lock_active, lock_hit;
  logic [DATA_W-1:0] mode0, mode1, dout, din32, rd_n, rd_q;
  logic [NUM_PADS-1:0] din_sync;

  assign lock_hit = bus_wr_en && (bus_addr[7:0] == OFF_LOCK);

  klg_key_lock u_lock (
    .clk(clk), .rst_n(rst_i_n), .wr_hit(lock_hit),
    .key(bus_wr_data[15:0]), .lock_active(lock_active)
  );

  klg_port_regs #(.NUM_PADS(NUM_PADS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_i_n), .wr_en(bus_wr_en), .addr(bus_addr),
    .wdata(bus_wr_data), .lock_active(lock_active),
    .mode0(mode0), .mode1(mode1), .dout(dout)
  );

  klg_pad_drive #(.NUM_PADS(NUM_PADS)) u_drive (
    .mode0(mode0[NUM_PADS-1:0]), .mode1(mode1[NUM_PADS-1:0]),
    .dout(dout[NUM_PADS-1:0]), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  klg_sync2 #(.WIDTH(NUM_PADS)) u_sync (
    .clk(clk), .rst_n(rst_i_n), .d(pad_in), .q(din_sync)
  );

  for (genvar i = 0; i < DATA_W; i++) begin : g_din
    if (i < NUM_PADS) begin : g_used
      assign din32[i] = din_sync[i];
    end else begin : g_unused
      assign din32[i] = 1'b0;
    end
  end

  always_comb begin
    unique case (bus_addr[7:0])
      OFF_DIN:   rd_n = din32;
      OFF_MODE1: rd_n = mode1;
      OFF_MODE0: rd_n = mode0;
      OFF_LOCK:  rd_n = {lock_active, {(DATA_W-1){1'b0}}};
      default:   rd_n = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)       rd_q <= '0;
    else if (bus_rd_en) rd_q <= rd_n;
  end
  assign bus_rd_data = rd_q;

  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_i_n)
    !bus_rd_en |=> $stable(bus_rd_data));
  assert_input_float_R4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (pad_oe & ~mode1[NUM_PADS-1:0] & ~mode0[NUM_PADS-1:0]) == '0);
  assert_od_never_high_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (pad_oe & pad_out & mode1[NUM_PADS-1:0] & ~mode0[NUM_PADS-1:0]) == '0);
  assert_os_never_low_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (pad_oe & ~pad_out & mode1[NUM_PADS-1:0] & mode0[NUM_PADS-1:0]) == '0);
endmodule

// File: tb/keylock_gpio_port_tb_top.sv
module keylock_gpio_port_tb_top;
  localparam int unsigned NP = 20;
  localparam logic [31:0] MSK = (32'd1 << NP) - 32'd1;

  logic clk = 1'b0;
  logic rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr_en, bus_rd_en;
  logic [31:0] bus_wr_data, bus_rd_data;
  logic [NP-1:0] pad_in, pad_out, pad_oe;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [31:0] m0, m1, d;
  logic        lk;

  always #10 clk = ~clk;

  keylock_gpio_port #(.NUM_PADS(NP), .ADDR_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wr_data(bus_wr_data), .bus_rd_en(bus_rd_en), .bus_rd_data(bus_rd_data),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_oe(input logic [31:0] a1, input logic [31:0] a0, input logic [31:0] dd);
    return ((~a1 & a0) | (a1 & ~a0 & ~dd) | (a1 & a0 & dd)) & MSK;
  endfunction
  function automatic logic [31:0] exp_out(input logic [31:0] a1, input logic [31:0] a0, input logic [31:0] dd);
    return ((~a1 & a0 & dd) | (a1 & a0 & dd)) & MSK;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    bus_addr = a; bus_wr_data = v; bus_wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr_en = 1'b0;
    case (a)
      8'h60: if (v[15:0] == 16'hD42F) lk = 1'b1; else if (v[15:0] == 16'h0) lk = 1'b0;
      8'h14: d = d | (v & MSK);
      8'h18: d = d & ~(v & MSK);
      8'h08: if (lk) m1 = v & MSK;
      8'h0C: if (lk) m0 = v & MSK;
      8'h50: if (lk) m1 = m1 & ~(v & MSK);
      8'h54: if (lk) m0 = m0 | (v & MSK);
      8'h58: if (lk) m0 = m0 & ~(v & MSK);
      default: ;
    endcase
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a; bus_rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_rd_en = 1'b0;
    v = bus_rd_data;
  endtask

  task automatic chk_pads(input string req);
    chk({req, " oe"}, 32'(pad_oe), exp_oe(m1, m0, d));
    chk({req, " out"}, 32'(pad_out & pad_oe), exp_out(m1, m0, d));
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [31:0] v, pv;
    void'($urandom(32'h5EED_0042));
    m0 = '0; m1 = '0; d = '0; lk = 1'b0;
    bus_addr = '0; bus_wr_en = 0; bus_rd_en = 0; bus_wr_data = '0; pad_in = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 oe", 32'(pad_oe), 32'h0);
    rd(8'h60, v); chk("R1 lock", v, 32'h0);
    rd(8'h0C, v); chk("R1 mode0", v, 32'h0);
    rd(8'h08, v); chk("R1 mode1", v, 32'h0);

    // R3: locked mode writes ignored
    wr(8'h0C, 32'hFFFF_FFFF); wr(8'h54, 32'hFFFF_FFFF); wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h0C, v); chk("R3 mode0 locked", v, 32'h0);
    rd(8'h08, v); chk("R3 mode1 locked", v, 32'h0);
    chk_pads("R3 pads locked");

    // R2: key arms, other value keeps, zero disarms
    wr(8'h60, 32'h0000_D42F); rd(8'h60, v); chk("R2 armed", v, 32'h8000_0000);
    wr(8'h60, 32'h0000_1234); rd(8'h60, v); chk("R2 other keeps", v, 32'h8000_0000);
    wr(8'h60, 32'hFFFF_0000); rd(8'h60, v); chk("R2 zero key disarms", v, 32'h0);
    wr(8'h60, 32'h0000_D42F);

    // R10: unused bits
    wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, v); chk("R10 mode0 mask", v, MSK);
    wr(8'h58, 32'hFFFF_FFFF); rd(8'h0C, v); chk("R8 mode0 clear", v, 32'h0);

    // R5/R6/R7/R12: modes on pads 0..3, data 0 then 1
    wr(8'h08, 32'h0000_000C); wr(8'h54, 32'h0000_000A);
    chk_pads("R4 R5 R6 R7 R12 data0");
    wr(8'h14, 32'h0000_000F);
    chk_pads("R4 R5 R6 R7 R12 data1");
    wr(8'h18, 32'h0000_0005);
    chk_pads("R8 data clear mixed");
    wr(8'h50, 32'h0000_0004); rd(8'h08, v); chk("R8 mode1 clear", v, 32'h0000_0008);

    // R11: set/clear and unmapped reads are zero, hold without rd_en
    rd(8'h14, v); chk("R11 dset read", v, 32'h0);
    rd(8'h18, v); chk("R11 dclr read", v, 32'h0);
    rd(8'h7C, v); chk("R11 unmapped", v, 32'h0);
    rd(8'h08, v); @(negedge clk); chk("R11 hold", bus_rd_data, 32'h0000_0008);

    // R9: synchroniser latency
    pv = 32'h0;
    for (int k = 0; k < 4; k++) begin
      v = $urandom & MSK;
      pad_in = v[NP-1:0];
      rd(8'h04, v); chk("R9 same cycle old", v, pv);
      rd(8'h04, v); chk("R9 next cycle old", v, pv);
      rd(8'h04, v); chk("R9 third read new", v, 32'(pad_in));
      pv = 32'(pad_in);
    end

    // random mix
    for (int it = 0; it < 400; it++) begin
      int sel;
      logic [31:0] r;
      sel = int'($urandom % 11);
      r = $urandom;
      case (sel)
        0: wr(8'h60, 32'h0000_D42F);
        1: wr(8'h60, 32'h0);
        2: wr(8'h60, (r[15:0] == 16'hD42F || r[15:0] == 16'h0) ? 32'h55 : r);
        3: wr(8'h08, r);
        4: wr(8'h0C, r);
        5: wr(8'h50, r);
        6: wr(8'h54, r);
        7: wr(8'h58, r);
        8: wr(8'h14, r);
        9: wr(8'h18, r);
        default: wr(8'h60, 32'h0000_D42F);
      endcase
      chk_pads("R3 R4 R5 R6 R7 R8 random");
      if (it % 8 == 0) begin
        rd(8'h0C, v); chk("R3 R8 R10 mode0 random", v, m0);
        rd(8'h08, v); chk("R3 R8 R10 mode1 random", v, m1);
        rd(8'h60, v); chk("R2 lock random", v, {lk, 31'h0});
      end
    end
    finish_run();
  end
endmodule